// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a parameterised register of WIDTH stages, four by default. Two mode-select bits choose, on every rising clock edge, one of four actions: clear all stages, shift toward the high end, shift toward the low end, or load the parallel input word. Each shift direction has its own serial input bit. Typical uses are serial-to-parallel and parallel-to-serial conversion, and a general register that sits on a shared bus.

A build-time parameter picks one of two output and reset styles. In the bus style, the outputs are three-state and gated by an output-enable pin. In the clear style, the outputs are always driven and an active-high asynchronous clear pin forces every stage to zero.

Top module: `ushift_reg`

## Requirements
- R1: With sel_i = 2'b11 (sel_i[1] is the upper select bit), a rising edge copies din_i into the stages, with bit i going to stage i.
- R2: During a load (sel_i = 2'b11), the values of sr_i and sl_i have no effect on the stored word.
- R3: With sel_i = 2'b01, a rising edge moves stage i-1 into stage i for every i of 1 or more, and sr_i enters stage 0.
- R4: With sel_i = 2'b10, a rising edge moves stage i+1 into stage i for every i below WIDTH-1, and sl_i enters stage WIDTH-1.
- R5: With sel_i = 2'b00, a rising edge sets every stage to zero.
- R6: With OUT_STYLE = 0 (bus style), q_o shows the stored word while oe_i is high. While oe_i is low, every bit of q_o is high impedance. oe_i acts combinationally and does not change the stored word.
- R7: With OUT_STYLE = 1 (clear style), a high level on clr_i sets every stage to zero at once, without waiting for a clock edge. The stages stay at zero across rising edges while clr_i is high, whatever the value of sel_i.
- R8: With OUT_STYLE = 1, once clr_i has fallen, the next rising edge acts on the register according to sel_i.
- R9: The pin that the chosen style does not use has no effect. With OUT_STYLE = 0, clr_i changes nothing. With OUT_STYLE = 1, q_o is driven with the stored word whatever the level of oe_i.
- R10: WIDTH must be 2 or more. Any such width uses the same mode encoding and the same shift rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| sel_i | input | 2 | Mode select: 00 clear, 01 shift up, 10 shift down, 11 load |
| din_i | input | WIDTH | Parallel load word |
| sr_i | input | 1 | Serial bit entering stage 0 on an up shift |
| sl_i | input | 1 | Serial bit entering stage WIDTH-1 on a down shift |
| oe_i | input | 1 | Output enable, active high (bus style only) |
| clr_i | input | 1 | Asynchronous clear, active high (clear style only) |
| q_o | output | WIDTH | Stage contents, three-state in the bus style |

## Verification
The bench targets the bit that enters at each end of a shift. A design that takes its serial bits from the wrong pin, or reverses the direction of a shift, gives the wrong end bits within one edge. It also toggles both serial inputs during loads and drives a known word onto the shared bus while the outputs are disabled. A design that leaks a serial bit into a load, or keeps driving while disabled, fails these checks. Clear pulses are raised and dropped between clock edges and held across a load edge. This exposes a clear that waits for the clock, one that leaks through in the bus style, and one that swallows the first edge after it falls. The clear-style instance is six bits wide, so a design whose shift rules are fixed at four bits also fails.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'b00,
        MODE_UP    = 2'b01,
        MODE_DOWN  = 2'b10,
        MODE_LOAD  = 2'b11
    } mode_e;

    localparam int STYLE_BUS   = 0;
    localparam int STYLE_CLEAR = 1;

endpackage

// File: rtl/ushift_decode.sv
module ushift_decode
    import ushift_pkg::*;
(
    input  logic [1:0] sel_i,
    output mode_e      mode_o
);
    always_comb begin
        unique case (sel_i)
            2'b00:   mode_o = MODE_CLEAR;
            2'b01:   mode_o = MODE_UP;
            2'b10:   mode_o = MODE_DOWN;
            default: mode_o = MODE_LOAD;
        endcase
    end
endmodule

// File: rtl/ushift_next.sv
module ushift_next
    import ushift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e             mode_i,
    input  logic [WIDTH-1:0]  cur_i,
    input  logic [WIDTH-1:0]  din_i,
    input  logic              sr_i,
    input  logic              sl_i,
    output logic [WIDTH-1:0]  nxt_o
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] up_src;
    logic [WIDTH-1:0] down_src;

    assign up_src   = {cur_i[TOP-1:0], sr_i};
    assign down_src = {sl_i, cur_i[TOP:1]};

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        always_comb begin
            unique case (mode_i)
                MODE_CLEAR: nxt_o[i] = 1'b0;
                MODE_UP:    nxt_o[i] = up_src[i];
                MODE_DOWN:  nxt_o[i] = down_src[i];
                default:    nxt_o[i] = din_i[i];
            endcase
        end
    end
endmodule

// File: rtl/ushift_drive.sv
module ushift_drive
    import ushift_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter int OUT_STYLE = STYLE_BUS
) (
    input  logic [WIDTH-1:0] bits_i,
    input  logic             oe_i,
    output logic [WIDTH-1:0] q_o
);
    if (OUT_STYLE == STYLE_BUS) begin : g_bus
        assign q_o = oe_i ? bits_i : {WIDTH{1'bz}};
    end else begin : g_plain
        logic unused_oe;
        assign unused_oe = oe_i;
        assign q_o = bits_i;
    end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter int OUT_STYLE = STYLE_BUS
) (
    input  logic             clk_i,
    input  logic [1:0]       sel_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             sr_i,
    input  logic             sl_i,
    input  logic             oe_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] q_o
);
    localparam bit HAS_CLR = (OUT_STYLE == STYLE_CLEAR);

    if (WIDTH < 2) begin : g_bad_width
        $error("ushift_reg: WIDTH must be at least 2 (R10)");
    end

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } reg_t;

    reg_t             r_d, r_q;
    mode_e            mode;
    logic [WIDTH-1:0] nxt;

    ushift_decode u_dec (
        .sel_i  (sel_i),
        .mode_o (mode)
    );

    ushift_next #(.WIDTH(WIDTH)) u_next (
        .mode_i (mode),
        .cur_i  (r_q.bits),
        .din_i  (din_i),
        .sr_i   (sr_i),
        .sl_i   (sl_i),
        .nxt_o  (nxt)
    );

    always_comb begin
        r_d      = r_q;
        r_d.bits = nxt;
    end

    if (HAS_CLR) begin : g_ff_clr
        always_ff @(posedge clk_i or posedge clr_i) begin
            if (clr_i) r_q <= '0;
            else       r_q <= r_d;
        end
    end else begin : g_ff_plain
        logic unused_clr;
        assign unused_clr = clr_i;
        always_ff @(posedge clk_i) begin
            r_q <= r_d;
        end
    end

    ushift_drive #(.WIDTH(WIDTH), .OUT_STYLE(OUT_STYLE)) u_drive (
        .bits_i (r_q.bits),
        .oe_i   (oe_i),
        .q_o    (q_o)
    );

    // ---------------- assertions ----------------
    logic live_q = 1'b0;
    always_ff @(posedge clk_i) live_q <= 1'b1;

    logic clr_hit;
    assign clr_hit = HAS_CLR && clr_i;

    a_r1_load: assert property (@(posedge clk_i) disable iff (!live_q || clr_hit)
        sel_i == 2'b11 |=> r_q.bits == $past(din_i));

    a_r3_up_shift: assert property (@(posedge clk_i) disable iff (!live_q || clr_hit)
        sel_i == 2'b01 |=> r_q.bits == {$past(r_q.bits[WIDTH-2:0]), $past(sr_i)});

    a_r4_down_shift: assert property (@(posedge clk_i) disable iff (!live_q || clr_hit)
        sel_i == 2'b10 |=> r_q.bits == {$past(sl_i), $past(r_q.bits[WIDTH-1:1])});

    a_r5_clear_mode: assert property (@(posedge clk_i) disable iff (!live_q || clr_hit)
        sel_i == 2'b00 |=> r_q.bits == '0);

    if (HAS_CLR) begin : g_chk_clr
        a_r7_clr_forces_zero: assert property (@(posedge clk_i) disable iff (!live_q)
            clr_i |-> r_q.bits == '0);
        a_r9_always_driven: assert property (@(posedge clk_i) disable iff (!live_q)
            !oe_i |-> q_o == r_q.bits);
    end else begin : g_chk_bus
        a_r6_enabled_shows: assert property (@(posedge clk_i) disable iff (!live_q)
            oe_i |-> q_o == r_q.bits);
    end
endmodule

// File: tb/ushift_reg_bench.sv
`timescale 1ns/1ps
module ushift_reg_bench;
    logic       clk = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [3:0] din4 = '0;
    logic [5:0] din6 = '0;
    logic       sr = 1'b0, sl = 1'b0, oe = 1'b1, clr = 1'b0;
    logic       bdrv = 1'b0;
    logic [3:0] bval = '0;
    tri   [3:0] bus4;
    logic [5:0] q6;

    logic [3:0] m4;
    logic [5:0] m6;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign bus4 = bdrv ? bval : 4'bzzzz;

    ushift_reg #(.WIDTH(4), .OUT_STYLE(0)) u_ushift_reg (
        .clk_i(clk), .sel_i(sel), .din_i(din4), .sr_i(sr), .sl_i(sl),
        .oe_i(oe), .clr_i(clr), .q_o(bus4));

    ushift_reg #(.WIDTH(6), .OUT_STYLE(1)) u_ushift_reg_clr (
        .clk_i(clk), .sel_i(sel), .din_i(din6), .sr_i(sr), .sl_i(sl),
        .oe_i(oe), .clr_i(clr), .q_o(q6));

    function automatic logic [7:0] model(input logic [7:0] cur, input int w,
                                         input logic [1:0] s, input logic [7:0] d,
                                         input logic r, input logic l);
        logic [7:0] mask;
        logic [7:0] res;
        mask = 8'((9'd1 << w) - 9'd1);
        case (s)
            2'b00:   res = 8'd0;
            2'b01:   res = (cur << 1) | {7'd0, r};
            2'b10:   res = (cur >> 1) | ({7'd0, l} << (w - 1));
            default: res = d;
        endcase
        return res & mask;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] s, input logic [3:0] d4, input logic [5:0] d6,
                        input logic r, input logic l, input string tag);
        @(negedge clk);
        sel = s; din4 = d4; din6 = d6; sr = r; sl = l;
        @(posedge clk);
        m4 = model({4'd0, m4}, 4, s, {4'd0, d4}, r, l)[3:0];
        if (clr) m6 = '0;
        else     m6 = model({2'd0, m6}, 6, s, {2'd0, d6}, r, l)[5:0];
        #1;
        if (oe) chk(bus4 == m4, {tag, " w4"}, {4'd0, bus4}, {4'd0, m4});
        chk(q6 == m6, {tag, " w6"}, {2'd0, q6}, {2'd0, m6});
    endtask

    initial begin
        m4 = '0; m6 = '0;
        void'($urandom(32'd7311));
        // R5: clear mode from power-up gives the reset state
        step(2'b00, 4'h0, 6'h00, 1'b1, 1'b1, "R5 reset clear");
        // R1 and R2: load with both serial bits high, then low
        step(2'b11, 4'hB, 6'h26, 1'b1, 1'b1, "R1 R2 load serial high");
        step(2'b11, 4'h6, 6'h19, 1'b0, 1'b0, "R1 R2 load serial low");
        // R3: up shifts, R10 on the six-bit copy
        step(2'b01, 4'h0, 6'h00, 1'b1, 1'b0, "R3 R10 up shift 1");
        step(2'b01, 4'h0, 6'h00, 1'b0, 1'b1, "R3 R10 up shift 0");
        step(2'b01, 4'h0, 6'h00, 1'b1, 1'b1, "R3 R10 up shift 1b");
        // R4: down shifts
        step(2'b10, 4'h0, 6'h00, 1'b0, 1'b1, "R4 R10 down shift 1");
        step(2'b10, 4'h0, 6'h00, 1'b1, 1'b0, "R4 R10 down shift 0");
        // R5: clear from a nonzero word
        step(2'b11, 4'hF, 6'h3F, 1'b0, 1'b0, "R1 load ones");
        step(2'b00, 4'hF, 6'h3F, 1'b1, 1'b1, "R5 clear");

        // R6: disabled outputs release the bus; storage keeps working
        step(2'b11, 4'h5, 6'h15, 1'b0, 1'b0, "R1 load before disable");
        @(negedge clk);
        oe = 1'b0; bdrv = 1'b1; bval = 4'hA;
        #1 chk(bus4 == 4'hA, "R6 bus released", {4'd0, bus4}, 8'h0A);
        chk(q6 == m6, "R9 oe ignored in clear style", {2'd0, q6}, {2'd0, m6});
        step(2'b11, 4'h9, 6'h2C, 1'b1, 1'b0, "R6 load while disabled");
        #1 chk(bus4 == 4'hA, "R6 still released", {4'd0, bus4}, 8'h0A);
        @(negedge clk);
        bdrv = 1'b0; oe = 1'b1;
        #1 chk(bus4 == m4, "R6 contents kept", {4'd0, bus4}, {4'd0, m4});

        // R7: clear between edges acts at once; R9: bus-style copy ignores it
        @(negedge clk);
        sel = 2'b11; din4 = 4'h3; din6 = 6'h33;
        clr = 1'b1;
        #1 chk(q6 == 6'h00, "R7 immediate clear", {2'd0, q6}, 8'h00);
        m6 = '0;
        chk(bus4 == m4, "R9 clr ignored in bus style", {4'd0, bus4}, {4'd0, m4});
        step(2'b11, 4'h3, 6'h33, 1'b0, 1'b0, "R7 R9 load edge under clear");
        step(2'b01, 4'h0, 6'h00, 1'b1, 1'b0, "R7 shift edge under clear");
        @(negedge clk);
        clr = 1'b0;
        step(2'b11, 4'hC, 6'h2B, 1'b0, 1'b1, "R8 first edge after release");
        step(2'b10, 4'h0, 6'h00, 1'b0, 1'b1, "R8 shift after release");

        // random mix over all modes, outputs enabled or not
        for (int k = 0; k < 400; k++) begin
            logic [1:0] rs;
            rs = 2'($urandom);
            oe = ($urandom % 4) != 0;
            step(rs, 4'($urandom), 6'($urandom), 1'($urandom), 1'($urandom),
                 (rs == 2'b00) ? "R5 random" : (rs == 2'b01) ? "R3 random" :
                 (rs == 2'b10) ? "R4 random" : "R1 R2 random");
        end
        @(negedge clk);
        oe = 1'b1;
        #1 chk(bus4 == m4, "R6 final enable", {4'd0, bus4}, {4'd0, m4});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule